// File: doc/BRIEF.md
# Component Video Sampling Sequencer

This block schedules a single shared 6-bit converter across the three components of a sub-picture: luma (Y) and the two colour-difference signals (R-Y and B-Y). It runs on a sample clock locked to 640 times the line rate. Each line is cut into repeating groups of eight sample slots. Luma takes every other slot, which gives it half the sample rate. Each colour-difference channel takes one slot per group, which gives it one eighth of the rate. The two remaining slots in each group stay idle.

From the incoming sync pulses, the block derives one-hot select strobes for the external input multiplexer. It also derives a clamp pulse whose position can be moved in coarse steps, and a converter clock enable. The enable is high only in the non-idle slots of the active capture window. The capture window covers 512 sample clocks per line, which gives 256 Y, 64 R-Y and 64 B-Y samples. Vertically it covers 80 lines in the 525-line standard and 84 lines in the 625-line standard. Both edges of the window can be moved in small steps.

The block sorts the returned converter words into three per-channel output registers. Each register has its own one-cycle valid bit. A downstream writer can therefore take each component as a separate stream.

Top module: `cvs_sampler`

## Requirements
- R1: The slot phase p counts sample clocks modulo 8. Y is selected for p = 0, 2, 4 and 6, R-Y for p = 1, B-Y for p = 3, and nothing for p = 5 and 7. At most one of sel_y, sel_ry and sel_by is high at any time.
- R2: The first clock edge that samples hsync_n low after it was high sets the phase and the horizontal position n to zero. So the cycle after that edge has p = 0 and n = 0, even if the previous line length was not a multiple of 8.
- R3: The horizontal window covers n from H_BASE + 3*hadj (default H_BASE = 96) for 512 clocks. A fully active line therefore yields exactly 256 Y, 64 R-Y and 64 B-Y samples.
- R4: The line number L is 0 after a vsync_n falling edge and rises by one at each hsync_n falling edge. The vertical window covers L from 8 + vadj for 80 lines when std_625 = 0 and for 84 lines when std_625 = 1.
- R5: clamp is high for exactly 8 clocks, at n from 48 + 8*clamp_adj to 55 + 8*clamp_adj. It is never high inside the horizontal window.
- R6: adc_clk_en is high exactly in the cycles that lie in both windows and carry a non-idle slot.
- R7: The adc_data present in a cycle with adc_clk_en high appears one cycle later on the output of its channel. In that same cycle a one-cycle pulse shows on sample_valid, where bit 0 is Y, bit 1 is R-Y and bit 2 is B-Y. Samples come out in slot order.
- R8: Idle slots and slots outside the window raise no valid bit. The data output of a channel changes only in a cycle in which its own valid bit is high.
- R9: While rst_n is low, and after reset before the first sync edge: no valid bit, no clamp, no converter enable, all sample outputs zero, and sel_y high with phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, 640 times the line rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_n | input | 1 | Sub-picture horizontal sync, active low |
| vsync_n | input | 1 | Sub-picture vertical sync, active low |
| std_625 | input | 1 | 1 selects the 84-line window, 0 the 80-line window |
| hadj | input | 2 | Horizontal window start offset, 3 clocks per step |
| vadj | input | 2 | Vertical window start offset, 1 line per step |
| clamp_adj | input | 2 | Clamp pulse position, 8 clocks per step |
| adc_data | input | 6 | Converter output word |
| sel_y | output | 1 | Input multiplexer select for luma |
| sel_ry | output | 1 | Input multiplexer select for R-Y |
| sel_by | output | 1 | Input multiplexer select for B-Y |
| adc_clk_en | output | 1 | Converter sample enable |
| clamp | output | 1 | Converter clamp pulse |
| sample_valid | output | 3 | Per-channel sample strobe: Y, R-Y, B-Y |
| y_sample | output | 6 | Latest luma sample |
| ry_sample | output | 6 | Latest R-Y sample |
| by_sample | output | 6 | Latest B-Y sample |

## Verification
If the slot phase is off, the select strobes and the converter enable show it in the same cycle. In the next cycle, words arrive on the wrong channel port, and the scoreboard catches that at the first captured slot. A wrong horizontal position moves the clamp pulse or the window edge, and cycle-by-cycle comparison of clamp and adc_clk_en shows this within one line. A wrong line count is invisible inside a line. It shows only as whole lines of missing or extra samples, which the per-channel totals checked at the end of each frame expose. Line lengths that are not a multiple of eight make any failure to realign the phase at horizontal sync visible within the first group of the next line.

// File: rtl/cvs_pkg.sv
package cvs_pkg;

   typedef enum logic [1:0] {
      SLOT_Y    = 2'd0,
      SLOT_RY   = 2'd1,
      SLOT_BY   = 2'd2,
      SLOT_IDLE = 2'd3
   } slot_e;

   localparam int unsigned NUM_CH     = 3;
   localparam int unsigned GROUP_LEN  = 8;
   localparam int unsigned PHASE_W    = 3;

   // fixed eight-slot pattern: luma on even phases, colour on 1 and 3
   function automatic slot_e slot_of(input logic [PHASE_W-1:0] ph);
      slot_e s;
      if (!ph[0])            s = SLOT_Y;
      else if (ph == 3'd1)   s = SLOT_RY;
      else if (ph == 3'd3)   s = SLOT_BY;
      else                   s = SLOT_IDLE;
      return s;
   endfunction

endpackage

// File: rtl/cvs_fall_detect.sv
module cvs_fall_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_n,
   output logic fall
);

   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= sig_n;
   end

   assign fall = prev_q & ~sig_n;

endmodule

// File: rtl/cvs_line_timer.sv
module cvs_line_timer #(
   parameter int unsigned HCNT_W      = 10,
   parameter int unsigned LCNT_W      = 10,
   parameter int unsigned H_BASE      = 96,
   parameter int unsigned H_STEP      = 3,
   parameter int unsigned WIN_CLKS    = 512,
   parameter int unsigned V_BASE      = 8,
   parameter int unsigned VLINES_525  = 80,
   parameter int unsigned VLINES_625  = 84,
   parameter int unsigned CLAMP_BASE  = 48,
   parameter int unsigned CLAMP_STEP  = 8,
   parameter int unsigned CLAMP_WIDTH = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        h_fall,
   input  logic                        v_fall,
   input  logic                        std_625,
   input  logic [1:0]                  hadj,
   input  logic [1:0]                  vadj,
   input  logic [1:0]                  clamp_adj,
   output logic [cvs_pkg::PHASE_W-1:0] phase,
   output logic                        h_active,
   output logic                        v_active,
   output logic                        clamp
);

   localparam logic [HCNT_W-1:0] HCNT_MAX = {HCNT_W{1'b1}};
   localparam logic [LCNT_W-1:0] LCNT_MAX = {LCNT_W{1'b1}};

   logic [HCNT_W-1:0] hcnt_q;
   logic [LCNT_W-1:0] lcnt_q;
   logic [HCNT_W-1:0] h_start, h_end, c_start, c_end;
   logic [LCNT_W-1:0] v_start, v_end, v_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= '0;
         hcnt_q <= HCNT_MAX;
         lcnt_q <= LCNT_MAX;
      end else begin
         if (h_fall) begin
            phase  <= '0;
            hcnt_q <= '0;
         end else begin
            phase <= phase + 1'b1;
            if (hcnt_q != HCNT_MAX) hcnt_q <= hcnt_q + 1'b1;
         end
         if (v_fall)
            lcnt_q <= '0;
         else if (h_fall && lcnt_q != LCNT_MAX)
            lcnt_q <= lcnt_q + 1'b1;
      end
   end

   assign h_start = HCNT_W'(H_BASE) + HCNT_W'(hadj) * HCNT_W'(H_STEP);
   assign h_end   = h_start + HCNT_W'(WIN_CLKS);
   assign c_start = HCNT_W'(CLAMP_BASE) + HCNT_W'(clamp_adj) * HCNT_W'(CLAMP_STEP);
   assign c_end   = c_start + HCNT_W'(CLAMP_WIDTH);
   assign v_len   = std_625 ? LCNT_W'(VLINES_625) : LCNT_W'(VLINES_525);
   assign v_start = LCNT_W'(V_BASE) + LCNT_W'(vadj);
   assign v_end   = v_start + v_len;

   assign h_active = (hcnt_q >= h_start) && (hcnt_q < h_end);
   assign v_active = (lcnt_q >= v_start) && (lcnt_q < v_end);
   assign clamp    = (hcnt_q >= c_start) && (hcnt_q < c_end);

   assert_clamp_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clamp |-> !h_active);

   assert_phase_steps_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !h_fall |=> phase == $past(phase) + 3'd1);

endmodule

// File: rtl/cvs_demux.sv
module cvs_demux #(
   parameter int unsigned DATA_W = 6
) (
   input  logic                                       clk,
   input  logic                                       rst_n,
   input  logic                                       take,
   input  cvs_pkg::slot_e                             slot,
   input  logic [DATA_W-1:0]                          din,
   output logic [cvs_pkg::NUM_CH-1:0]                 valid,
   output logic [cvs_pkg::NUM_CH-1:0][DATA_W-1:0]     dout
);

   for (genvar c = 0; c < cvs_pkg::NUM_CH; c++) begin : g_ch
      logic hit;
      assign hit = take && (slot == cvs_pkg::slot_e'(c));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid[c] <= 1'b0;
            dout[c]  <= '0;
         end else begin
            valid[c] <= hit;
            if (hit) dout[c] <= din;
         end
      end

      assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
         !valid[c] |-> $stable(dout[c]));

      assert_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
         valid[c] |-> dout[c] == $past(din));
   end

   assert_valid_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(valid));

endmodule

// File: rtl/cvs_sampler.sv
module cvs_sampler #(
   parameter int unsigned DATA_W      = 6,
   parameter int unsigned HCNT_W      = 10,
   parameter int unsigned LCNT_W      = 10,
   parameter int unsigned GROUPS      = 64,
   parameter int unsigned H_BASE      = 96,
   parameter int unsigned H_STEP      = 3,
   parameter int unsigned V_BASE      = 8,
   parameter int unsigned VLINES_525  = 80,
   parameter int unsigned VLINES_625  = 84,
   parameter int unsigned CLAMP_BASE  = 48,
   parameter int unsigned CLAMP_STEP  = 8,
   parameter int unsigned CLAMP_WIDTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hsync_n,
   input  logic              vsync_n,
   input  logic              std_625,
   input  logic [1:0]        hadj,
   input  logic [1:0]        vadj,
   input  logic [1:0]        clamp_adj,
   input  logic [DATA_W-1:0] adc_data,
   output logic              sel_y,
   output logic              sel_ry,
   output logic              sel_by,
   output logic              adc_clk_en,
   output logic              clamp,
   output logic [2:0]        sample_valid,
   output logic [DATA_W-1:0] y_sample,
   output logic [DATA_W-1:0] ry_sample,
   output logic [DATA_W-1:0] by_sample
);
   import cvs_pkg::*;

   localparam int unsigned WIN_CLKS  = GROUPS * GROUP_LEN;
   localparam int unsigned CLAMP_END = CLAMP_BASE + 3 * CLAMP_STEP + CLAMP_WIDTH;
   localparam int unsigned WIN_LAST  = H_BASE + 3 * H_STEP + WIN_CLKS;
   localparam int unsigned VWIN_LAST = V_BASE + 3 + VLINES_625;

   if (DATA_W < 1) begin : g_bad_width
      $error("cvs_sampler: DATA_W must be at least 1");
   end
   if (H_BASE < CLAMP_END) begin : g_bad_clamp
      $error("cvs_sampler: clamp range overlaps the capture window");
   end
   if (WIN_LAST >= (1 << HCNT_W)) begin : g_bad_hcnt
      $error("cvs_sampler: HCNT_W too small for the window");
   end
   if (VWIN_LAST >= (1 << LCNT_W) || VLINES_525 > VLINES_625 + 255) begin : g_bad_lcnt
      $error("cvs_sampler: LCNT_W too small for the vertical window");
   end

   logic               h_fall, v_fall;
   logic [PHASE_W-1:0] phase;
   logic               h_active, v_active;
   slot_e              slot;
   logic [NUM_CH-1:0][DATA_W-1:0] ch_data;

   cvs_fall_detect i_hs_edge (.clk(clk), .rst_n(rst_n), .sig_n(hsync_n), .fall(h_fall));
   cvs_fall_detect i_vs_edge (.clk(clk), .rst_n(rst_n), .sig_n(vsync_n), .fall(v_fall));

   cvs_line_timer #(
      .HCNT_W(HCNT_W), .LCNT_W(LCNT_W), .H_BASE(H_BASE), .H_STEP(H_STEP),
      .WIN_CLKS(WIN_CLKS), .V_BASE(V_BASE), .VLINES_525(VLINES_525),
      .VLINES_625(VLINES_625), .CLAMP_BASE(CLAMP_BASE), .CLAMP_STEP(CLAMP_STEP),
      .CLAMP_WIDTH(CLAMP_WIDTH)
   ) i_timer (
      .clk(clk), .rst_n(rst_n), .h_fall(h_fall), .v_fall(v_fall),
      .std_625(std_625), .hadj(hadj), .vadj(vadj), .clamp_adj(clamp_adj),
      .phase(phase), .h_active(h_active), .v_active(v_active), .clamp(clamp)
   );

   assign slot       = slot_of(phase);
   assign sel_y      = (slot == SLOT_Y);
   assign sel_ry     = (slot == SLOT_RY);
   assign sel_by     = (slot == SLOT_BY);
   assign adc_clk_en = h_active && v_active && (slot != SLOT_IDLE);

   cvs_demux #(.DATA_W(DATA_W)) i_demux (
      .clk(clk), .rst_n(rst_n), .take(adc_clk_en), .slot(slot),
      .din(adc_data), .valid(sample_valid), .dout(ch_data)
   );

   assign y_sample  = ch_data[0];
   assign ry_sample = ch_data[1];
   assign by_sample = ch_data[2];

   assert_ry_then_y_R1: assert property (@(posedge clk) disable iff (!rst_n)
      sel_ry |=> sel_y);

   assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      h_fall |=> sel_y && !adc_clk_en);

   assert_en_in_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      adc_clk_en |-> (sel_y || sel_ry || sel_by) && !clamp);

   assert_valid_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_valid != 3'b000) |-> $past(adc_clk_en));

endmodule

// File: tb/test_cvs_sampler.sv
module test_cvs_sampler;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hsync_n = 1'b1;
   logic       vsync_n = 1'b1;
   logic       std_625 = 1'b0;
   logic [1:0] hadj = 2'd0;
   logic [1:0] vadj = 2'd0;
   logic [1:0] clamp_adj = 2'd0;
   logic [5:0] adc_data = 6'd0;
   logic       sel_y, sel_ry, sel_by, adc_clk_en, clamp;
   logic [2:0] sample_valid;
   logic [5:0] y_sample, ry_sample, by_sample;

   always #5 clk = ~clk;

   cvs_sampler i_cvs_sampler (
      .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .vsync_n(vsync_n),
      .std_625(std_625), .hadj(hadj), .vadj(vadj), .clamp_adj(clamp_adj),
      .adc_data(adc_data), .sel_y(sel_y), .sel_ry(sel_ry), .sel_by(sel_by),
      .adc_clk_en(adc_clk_en), .clamp(clamp), .sample_valid(sample_valid),
      .y_sample(y_sample), .ry_sample(ry_sample), .by_sample(by_sample)
   );

   typedef struct { int ch; logic [5:0] d; } item_t;
   item_t exp_q[$];

   int   n_checks = 0;
   int   n_errors = 0;
   bit   mon_on = 1'b0;
   bit   done = 1'b0;
   int   cnt_ch[3];
   logic [5:0] last_v[3];

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic logic [5:0] port_data(int ch);
      case (ch)
         0:       return y_sample;
         1:       return ry_sample;
         default: return by_sample;
      endcase
   endfunction

   // monitor: pops the scoreboard as samples leave the design
   always @(negedge clk) begin
      if (mon_on) begin
         if (sample_valid != 3'b000) begin
            check($countones(sample_valid) == 1, "R7", "valid bits one-hot",
                  int'(sample_valid), 1);
            if (exp_q.size() == 0) begin
               check(1'b0, "R8", "valid with no sample due", int'(sample_valid), 0);
            end else begin
               item_t it;
               it = exp_q.pop_front();
               check(sample_valid == 3'(1 << it.ch), "R7", "channel tag",
                     int'(sample_valid), 1 << it.ch);
               check(port_data(it.ch) == it.d, "R7", "sample word",
                     int'(port_data(it.ch)), int'(it.d));
               last_v[it.ch] = it.d;
               cnt_ch[it.ch]++;
            end
         end
         for (int c = 0; c < 3; c++) begin
            if (!sample_valid[c])
               check(port_data(c) == last_v[c], "R8", "channel output held",
                     int'(port_data(c)), int'(last_v[c]));
         end
      end
   end

   // driver: one line of len+1 clocks; line number ln as seen after vsync
   task automatic run_line(int ln, int len, bit s625, int va, int ha, int ca);
      int vl;
      vl = s625 ? 84 : 80;
      @(negedge clk);
      hsync_n = 1'b0;
      for (int n = 0; n < len; n++) begin
         int  ph;
         bit  hwin, vwin, cl, is_y, is_ry, is_by, en;
         logic [5:0] d;
         @(negedge clk);
         if (n == 3) hsync_n = 1'b1;
         ph    = n % 8;
         is_y  = (ph % 2) == 0;
         is_ry = ph == 1;
         is_by = ph == 3;
         hwin  = (n >= 96 + 3 * ha) && (n < 96 + 3 * ha + 512);
         vwin  = (ln >= 8 + va) && (ln < 8 + va + vl);
         cl    = (n >= 48 + 8 * ca) && (n < 56 + 8 * ca);
         en    = hwin && vwin && (is_y || is_ry || is_by);
         check({sel_y, sel_ry, sel_by} == {is_y, is_ry, is_by}, "R1",
               "slot strobes", int'({sel_y, sel_ry, sel_by}), int'({is_y, is_ry, is_by}));
         if (n < 8)
            check(sel_y == is_y, "R2", "phase realigned after hsync", int'(sel_y), int'(is_y));
         check(clamp == cl, "R5", "clamp pulse", int'(clamp), int'(cl));
         check(adc_clk_en == en, "R6", "converter enable", int'(adc_clk_en), int'(en));
         d = 6'((n * 5 + ln * 3) & 63);
         adc_data = d;
         if (en) begin
            item_t it;
            it.ch = is_y ? 0 : (is_ry ? 1 : 2);
            it.d  = d;
            exp_q.push_back(it);
         end
      end
   endtask

   task automatic run_frame(bit s625, int va, int ha, int ca, int len);
      int vl, nl;
      vl = s625 ? 84 : 80;
      nl = 8 + va + vl + 2;
      @(negedge clk);
      std_625 = s625;
      vadj = 2'(va);
      hadj = 2'(ha);
      clamp_adj = 2'(ca);
      vsync_n = 1'b0;
      repeat (8) @(negedge clk);
      vsync_n = 1'b1;
      repeat (4) @(negedge clk);
      for (int c = 0; c < 3; c++) cnt_ch[c] = 0;
      for (int ln = 1; ln <= nl; ln++) run_line(ln, len, s625, va, ha, ca);
      repeat (3) @(negedge clk);
      check(cnt_ch[0] == vl * 256, "R3", "luma samples per frame (R4 lines)", cnt_ch[0], vl * 256);
      check(cnt_ch[1] == vl * 64, "R4", "R-Y samples per frame", cnt_ch[1], vl * 64);
      check(cnt_ch[2] == vl * 64, "R3", "B-Y samples per frame", cnt_ch[2], vl * 64);
      check(exp_q.size() == 0, "R8", "samples still pending", exp_q.size(), 0);
   endtask

   initial begin
      for (int c = 0; c < 3; c++) begin
         last_v[c] = 6'd0;
         cnt_ch[c] = 0;
      end
      repeat (3) @(negedge clk);
      // R9: state during reset
      check(sample_valid == 3'b000, "R9", "valid in reset", int'(sample_valid), 0);
      check(clamp == 1'b0, "R9", "clamp in reset", int'(clamp), 0);
      check(adc_clk_en == 1'b0, "R9", "enable in reset", int'(adc_clk_en), 0);
      check(sel_y == 1'b1, "R9", "phase zero in reset", int'(sel_y), 1);
      check({y_sample, ry_sample, by_sample} == 18'd0, "R9", "samples in reset",
            int'({y_sample, ry_sample, by_sample}), 0);
      rst_n = 1'b1;
      mon_on = 1'b1;
      repeat (20) @(negedge clk);
      check(adc_clk_en == 1'b0 && clamp == 1'b0, "R9", "idle before first sync",
            int'({adc_clk_en, clamp}), 0);
      // 625-line window, late offsets, 641-clock lines
      run_frame(1'b1, 3, 2, 1, 640);
      // 525-line window, zero offsets, last clamp step, 651-clock lines
      run_frame(1'b0, 0, 0, 3, 650);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule